// File: doc/BRIEF.md
# Single-Bit Set, Clear and Invert Unit

This block changes exactly one bit of a byte-wide operand. The operand comes either from a general register or from a byte returned by a memory read, picked by a select input. A 2-bit operation code forces the chosen bit to one, forces it to zero, flips it, or passes the byte through unchanged. The position of the bit is given by a 3-bit immediate field or by the three least significant bits of a second register. A source-select input chooses between the two, and the register's upper bits have no effect.

One registered stage follows the datapath. When `in_valid` is high at a rising clock edge, the block captures the modified byte and the value the chosen bit held before the change. It raises `out_valid` for the next cycle. The captured bit serves as a test result for flag updates. Bus sequencing and instruction decoding are left to the surrounding pipeline.

Top module: `bit_modify_unit`

## Requirements
- R1: With `op_code` = 2'b00 (set), the captured byte equals the operand with the selected bit forced to 1 and every other bit unchanged.
- R2: With `op_code` = 2'b01 (clear), the captured byte equals the operand with the selected bit forced to 0 and every other bit unchanged.
- R3: With `op_code` = 2'b10 (invert), the captured byte equals the operand with only the selected bit complemented.
- R4: With `op_code` = 2'b11, the captured byte equals the operand unchanged.
- R5: With `idx_src` = 0, the bit position is `idx_imm[2:0]`. With `idx_src` = 1, it is `idx_reg[2:0]`.
- R6: With `idx_src` = 1, bits 7 down to 3 of `idx_reg` do not affect any output.
- R7: With `opnd_sel` = 0, the operand is `opnd_reg`. With `opnd_sel` = 1, it is `opnd_mem`.
- R8: `out_prev_bit` equals the selected bit of the operand before modification, captured together with `out_byte`.
- R9: `out_valid` is high in the cycle after every edge with `in_valid` high, and low otherwise. While `in_valid` is low, `out_byte` and `out_prev_bit` hold their values.
- R10: While `rst_n` is low, `out_valid`, `out_byte` and `out_prev_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture request for this cycle |
| opnd_sel | input | 1 | Operand source: 0 register, 1 memory |
| opnd_reg | input | 8 | Operand from a general register |
| opnd_mem | input | 8 | Operand from a memory read |
| op_code | input | 2 | 00 set, 01 clear, 10 invert, 11 pass |
| idx_src | input | 1 | Bit-number source: 0 immediate, 1 register |
| idx_imm | input | 3 | Immediate bit number |
| idx_reg | input | 8 | Register holding the bit number in its low three bits |
| out_valid | output | 1 | Captured result is valid |
| out_byte | output | 8 | Modified byte |
| out_prev_bit | output | 1 | Selected bit before modification |

## Verification
A wrong lane decode or a bad index source shows up one cycle after the capturing edge. It appears either as more than one bit of `out_byte` differing from the operand, or as the wrong bit changing. In the same cycle, `out_prev_bit` disagrees with the operand. A fault in the output register shows as `out_valid` or the held byte changing on an idle cycle, on the very next edge. The bench compares every cycle against a behavioural model. It sweeps all eight positions for each code, places garbage in the upper bits of the index register, and gives the two operand sources different values, so that a wrong selection changes the byte.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
   typedef enum logic [1:0] {
      BMU_OP_SET  = 2'b00,
      BMU_OP_CLR  = 2'b01,
      BMU_OP_INV  = 2'b10,
      BMU_OP_KEEP = 2'b11
   } bmu_op_e;

   typedef enum logic {
      BMU_IDX_IMM = 1'b0,
      BMU_IDX_REG = 1'b1
   } bmu_idx_src_e;

   typedef enum logic {
      BMU_OPND_REG = 1'b0,
      BMU_OPND_MEM = 1'b1
   } bmu_opnd_src_e;
endpackage

// File: rtl/bmu_index_sel.sv
module bmu_index_sel #(
   parameter int DATA_W = 8,
   parameter int REG_W  = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              idx_src,
   input  logic [IDX_W-1:0]  idx_imm,
   input  logic [REG_W-1:0]  idx_reg,
   output logic [DATA_W-1:0] lane_mask
);
   import bmu_pkg::*;

   logic [IDX_W-1:0] idx_eff;

   generate
      if (REG_W < IDX_W) begin : g_bad_reg_w
         $error("bmu_index_sel: REG_W narrower than the bit index");
      end
      if ((1 << IDX_W) != DATA_W) begin : g_bad_data_w
         $error("bmu_index_sel: DATA_W must be a power of two");
      end
   endgenerate

   // only the low index bits of the register take part
   always_comb begin
      if (bmu_idx_src_e'(idx_src) == BMU_IDX_REG)
         idx_eff = idx_reg[IDX_W-1:0];
      else
         idx_eff = idx_imm;
   end

   for (genvar g = 0; g < DATA_W; g++) begin : g_dec
      assign lane_mask[g] = (idx_eff == IDX_W'(g));
   end
endmodule

// File: rtl/bmu_bit_alu.sv
module bmu_bit_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] lane_mask,
   input  logic [1:0]        op_code,
   output logic [DATA_W-1:0] result,
   output logic              prev_bit
);
   import bmu_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("bmu_bit_alu: DATA_W must be at least 2");
      end
   endgenerate

   for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      always_comb begin
         if (!lane_mask[g]) begin
            result[g] = operand[g];
         end else begin
            case (bmu_op_e'(op_code))
               BMU_OP_SET:  result[g] = 1'b1;
               BMU_OP_CLR:  result[g] = 1'b0;
               BMU_OP_INV:  result[g] = ~operand[g];
               default:     result[g] = operand[g];
            endcase
         end
      end
   end

   assign prev_bit = |(operand & lane_mask);
endmodule

// File: rtl/bmu_out_stage.sv
module bmu_out_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d_byte,
   input  logic              d_bit,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_byte,
   output logic              q_bit
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_byte  <= '0;
         q_bit   <= 1'b0;
      end else begin
         q_valid <= load;
         if (load) begin
            q_byte <= d_byte;
            q_bit  <= d_bit;
         end
      end
   end
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit #(
   parameter int DATA_W = 8,
   parameter int REG_W  = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              opnd_sel,
   input  logic [DATA_W-1:0] opnd_reg,
   input  logic [DATA_W-1:0] opnd_mem,
   input  logic [1:0]        op_code,
   input  logic              idx_src,
   input  logic [IDX_W-1:0]  idx_imm,
   input  logic [REG_W-1:0]  idx_reg,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_byte,
   output logic              out_prev_bit
);
   import bmu_pkg::*;

   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] alu_byte;
   logic              alu_bit;

   assign operand = (bmu_opnd_src_e'(opnd_sel) == BMU_OPND_MEM) ? opnd_mem : opnd_reg;

   bmu_index_sel #(.DATA_W(DATA_W), .REG_W(REG_W)) u_idx (
      .idx_src  (idx_src),
      .idx_imm  (idx_imm),
      .idx_reg  (idx_reg),
      .lane_mask(lane_mask)
   );

   bmu_bit_alu #(.DATA_W(DATA_W)) u_alu (
      .operand  (operand),
      .lane_mask(lane_mask),
      .op_code  (op_code),
      .result   (alu_byte),
      .prev_bit (alu_bit)
   );

   bmu_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (in_valid),
      .d_byte (alu_byte),
      .d_bit  (alu_bit),
      .q_valid(out_valid),
      .q_byte (out_byte),
      .q_bit  (out_prev_bit)
   );
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
   parameter int DATA_W = 8,
   parameter int REG_W  = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              opnd_sel,
   input logic [DATA_W-1:0] opnd_reg,
   input logic [DATA_W-1:0] opnd_mem,
   input logic [1:0]        op_code,
   input logic              idx_src,
   input logic [IDX_W-1:0]  idx_imm,
   input logic [REG_W-1:0]  idx_reg,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_byte,
   input logic              out_prev_bit
);
   logic [DATA_W-1:0] chk_opnd;
   logic [IDX_W-1:0]  chk_idx;
   logic              chk_bit;

   assign chk_opnd = opnd_sel ? opnd_mem : opnd_reg;
   assign chk_idx  = idx_src ? idx_reg[IDX_W-1:0] : idx_imm;
   assign chk_bit  = chk_opnd[chk_idx];

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_byte) && $stable(out_prev_bit)));

   assert_set_one_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == 2'b00) |=>
         (($countones(out_byte ^ $past(chk_opnd)) <= 1) &&
          ((out_byte & $past(chk_opnd)) == $past(chk_opnd))));

   assert_clear_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == 2'b01) |=>
         (($countones(out_byte ^ $past(chk_opnd)) <= 1) &&
          ((out_byte | $past(chk_opnd)) == $past(chk_opnd))));

   assert_invert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == 2'b10) |=>
         ($countones(out_byte ^ $past(chk_opnd)) == 1));

   assert_keep_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == 2'b11) |=> (out_byte == $past(chk_opnd)));

   assert_prev_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_prev_bit == $past(chk_bit)));
endmodule

bind bit_modify_unit bmu_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .opnd_sel    (opnd_sel),
   .opnd_reg    (opnd_reg),
   .opnd_mem    (opnd_mem),
   .op_code     (op_code),
   .idx_src     (idx_src),
   .idx_imm     (idx_imm),
   .idx_reg     (idx_reg),
   .out_valid   (out_valid),
   .out_byte    (out_byte),
   .out_prev_bit(out_prev_bit)
);

// File: tb/bit_modify_unit_tb_top.sv
module bit_modify_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       opnd_sel = 1'b0;
   logic [7:0] opnd_reg = 8'h00;
   logic [7:0] opnd_mem = 8'h00;
   logic [1:0] op_code = 2'b00;
   logic       idx_src = 1'b0;
   logic [2:0] idx_imm = 3'd0;
   logic [7:0] idx_reg = 8'h00;
   logic       out_valid;
   logic [7:0] out_byte;
   logic       out_prev_bit;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   // reference model state
   logic       exp_v = 1'b0;
   logic [7:0] exp_byte = 8'h00;
   logic       exp_bit = 1'b0;
   string      exp_tag = "R10";
   string      cur_tag = "R9";

   always #2.5 clk = ~clk;

   bit_modify_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_sel(opnd_sel),
      .opnd_reg(opnd_reg), .opnd_mem(opnd_mem), .op_code(op_code),
      .idx_src(idx_src), .idx_imm(idx_imm), .idx_reg(idx_reg),
      .out_valid(out_valid), .out_byte(out_byte), .out_prev_bit(out_prev_bit)
   );

   function automatic string op_tag(input logic [1:0] c);
      case (c)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   always @(posedge clk) begin
      int pos;
      logic [7:0] src;
      logic [7:0] res;
      if (!rst_n) begin
         exp_v    <= 1'b0;
         exp_byte <= 8'h00;
         exp_bit  <= 1'b0;
         exp_tag  <= "R10";
      end else begin
         exp_v <= in_valid;
         if (in_valid) begin
            src = opnd_sel ? opnd_mem : opnd_reg;
            pos = idx_src ? (idx_reg % 8) : int'(idx_imm);
            res = src;
            if (op_code == 2'b00) res[pos] = 1'b1;
            else if (op_code == 2'b01) res[pos] = 1'b0;
            else if (op_code == 2'b10) res[pos] = !src[pos];
            exp_byte <= res;
            exp_bit  <= src[pos];
            exp_tag  <= cur_tag;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         check(rst_n ? "R9 valid" : "R10 valid", out_valid, exp_v);
         check({exp_tag, " byte"}, out_byte, exp_byte);
         check(rst_n ? "R8 prev_bit" : "R10 prev_bit", out_prev_bit, exp_bit);
      end
   end

   task automatic issue(input logic s_mem, input logic [7:0] r, input logic [7:0] m,
                        input logic [1:0] c, input logic s_idx, input logic [2:0] imm,
                        input logic [7:0] ireg, input string tag);
      @(negedge clk);
      in_valid = 1'b1; opnd_sel = s_mem; opnd_reg = r; opnd_mem = m;
      op_code = c; idx_src = s_idx; idx_imm = imm; idx_reg = ireg;
      cur_tag = tag;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         // scramble inputs: R9 says outputs must hold
         opnd_reg = opnd_reg ^ 8'h5A; op_code = op_code + 2'd1;
         cur_tag = "R9";
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 R2 R3 R4: every code, every immediate position, two patterns
      for (int c = 0; c < 4; c++)
         for (int b = 0; b < 8; b++) begin
            issue(1'b0, 8'hA5, 8'h00, 2'(c), 1'b0, 3'(b), 8'hFF, op_tag(2'(c)));
            issue(1'b0, 8'h3C, 8'hFF, 2'(c), 1'b0, 3'(b), 8'h00, op_tag(2'(c)));
         end
      idle(3);
      // R5 R6: index from register with junk in upper bits; immediate disagrees
      for (int c = 0; c < 3; c++)
         for (int b = 0; b < 8; b++)
            issue(1'b0, 8'h96, 8'h69, 2'(c), 1'b1, 3'(7 - b), 8'(8'hF8 ^ (b << 3) | b),
                  (b % 2 == 0) ? "R5" : "R6");
      idle(2);
      // R7: memory operand differs from register operand
      for (int c = 0; c < 4; c++)
         for (int b = 0; b < 8; b += 3)
            issue(1'b1, 8'h0F, 8'hC3, 2'(c), 1'b0, 3'(b), 8'h00, "R7");
      issue(1'b0, 8'h0F, 8'hC3, 2'b10, 1'b1, 3'd0, 8'h05, "R7");
      idle(4);
      // R10: reset in the middle of traffic
      issue(1'b0, 8'h81, 8'h00, 2'b10, 1'b0, 3'd7, 8'h00, "R3");
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; in_valid = 1'b0;
      issue(1'b0, 8'h00, 8'h00, 2'b00, 1'b0, 3'd4, 8'h00, "R1");
      idle(3);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule